// File: doc/BRIEF.md
# Multicycle Unit Busy-Flag Scoreboard

This block is the issue interlock for a pipeline in which several long-latency execution units run side by side: a floating-point adder, a floating-point multiplier, a floating-point divider and an integer multiplier. It keeps one busy flag for each execution unit and one for each result register. A register flag marks that register as the destination of an operation still in flight. Each cycle the block looks at the instruction waiting in decode and says whether that instruction may leave. When it does leave, the block sets the flags the instruction claims.

Instructions leave decode strictly in program order. A stalled instruction is held in decode until it may go. Results may come back in any order. Each unit reports a finished operation with a one-cycle completion pulse that carries the register written. The unit's own internals and the result bypass network sit outside this block.

Top module: `mcu_busy_scoreboard`

## Requirements
- R1: After reset, every unit flag and every register flag is clear. With no request present, stall is low.
- R2: A valid request that names a non-pipelined unit whose busy flag is set raises stall in the same cycle (structural hazard).
- R3: A valid request raises stall when a source it marks as used (srcAUse or srcBUse high) names a busy register. A source whose use bit is low is ignored (read-after-write hazard).
- R4: A valid request whose destination register is busy raises stall (write-after-write hazard).
- R5: Stall is low whenever issueValid is low, whatever the flags hold.
- R6: A request that is valid and not stalled issues. From the next cycle its destination register flag is set. The flag of its unit is also set, unless that unit is pipelined.
- R7: A unit selected by the PIPE_MASK bit (unit index 0, the FP adder, by default) never shows busy. It accepts a new request every cycle, limited only by register hazards.
- R8: A completion pulse on doneValid[u] clears the flag of unit u from the next cycle. It also clears the flag of the register given in slice u of doneRegs (bits u*REG_W upward).
- R9: Completion pulses from different units in the same cycle each clear their own unit and register flags.
- R10: A stalled request changes no flag. While it is held, the flags change only through completion pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | A decoded instruction is waiting in decode |
| issueUnit | input | UNIT_W | Index of the execution unit it needs |
| srcA | input | REG_W | First source register |
| srcAUse | input | 1 | First source is read by this instruction |
| srcB | input | REG_W | Second source register |
| srcBUse | input | 1 | Second source is read by this instruction |
| dst | input | REG_W | Destination register |
| doneValid | input | NUM_UNITS | Per-unit completion pulse |
| doneRegs | input | NUM_UNITS*REG_W | Per-unit destination of the completing operation |
| stall | output | 1 | Hold the instruction in decode this cycle |
| unitBusy | output | NUM_UNITS | Unit busy flags |
| regBusy | output | NUM_REGS | Register busy flags |

## Verification
The bench uses the default build: four units, 32 registers, and only the adder pipelined. Sources and destinations are drawn from the low eight registers, so read-after-write, write-after-write and structural conflicts happen often. A latency model in the bench produces completions: 4 cycles for the adder and multiplier, 10 or 23 for the divider, and 8 to 16 for the integer multiplier. These spreads make completions arrive out of order and sometimes in the same cycle, which brings both the simultaneous-clear case and back-to-back adder issue within reach.

// File: rtl/mcsb_pkg.sv
package mcsb_pkg;
  // Strobes from the hazard control to the flag datapath
  typedef struct packed {
    logic fire;       // request leaves decode this cycle
    logic claimUnit;  // mark the selected unit busy
    logic claimReg;   // mark the destination register busy
  } issueStrobe_t;
endpackage

// File: rtl/mcsb_ctrl.sv
module mcsb_ctrl
  import mcsb_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int NUM_REGS  = 32,
  parameter logic [NUM_UNITS-1:0] PIPE_MASK = 4'b0001,
  localparam int UNIT_W = $clog2(NUM_UNITS),
  localparam int REG_W  = $clog2(NUM_REGS)
) (
  input  logic                 issueValid,
  input  logic [UNIT_W-1:0]    issueUnit,
  input  logic [REG_W-1:0]     srcA,
  input  logic                 srcAUse,
  input  logic [REG_W-1:0]     srcB,
  input  logic                 srcBUse,
  input  logic [REG_W-1:0]     dst,
  input  logic [NUM_UNITS-1:0] unitBusy,
  input  logic [NUM_REGS-1:0]  regBusy,
  output logic                 stall,
  output issueStrobe_t         strobe
);
  logic unitHaz, rawHaz, wawHaz, anyHaz;

  always_comb begin
    unitHaz = unitBusy[issueUnit];
    rawHaz  = (srcAUse && regBusy[srcA]) || (srcBUse && regBusy[srcB]);
    wawHaz  = regBusy[dst];
    anyHaz  = unitHaz || rawHaz || wawHaz;
    stall   = issueValid && anyHaz;
    strobe.fire      = issueValid && !anyHaz;
    strobe.claimUnit = strobe.fire && !PIPE_MASK[issueUnit];
    strobe.claimReg  = strobe.fire;
  end
endmodule

// File: rtl/mcsb_flags.sv
module mcsb_flags
  import mcsb_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int NUM_REGS  = 32,
  parameter logic [NUM_UNITS-1:0] PIPE_MASK = 4'b0001,
  localparam int UNIT_W = $clog2(NUM_UNITS),
  localparam int REG_W  = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  issueStrobe_t               strobe,
  input  logic [UNIT_W-1:0]          issueUnit,
  input  logic [REG_W-1:0]           dst,
  input  logic [NUM_UNITS-1:0]       doneValid,
  input  logic [NUM_UNITS*REG_W-1:0] doneRegs,
  output logic [NUM_UNITS-1:0]       unitBusy,
  output logic [NUM_REGS-1:0]        regBusy
);
  logic [NUM_REGS-1:0] regClr, regSet, regBusyQ;

  // Unit flags: a pipelined unit takes one request per cycle and never holds
  for (genvar u = 0; u < NUM_UNITS; u++) begin : gUnit
    if (PIPE_MASK[u]) begin : gPipe
      assign unitBusy[u] = 1'b0;
    end else begin : gHold
      logic busyQ;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          busyQ <= 1'b0;
        end else if (strobe.claimUnit && issueUnit == UNIT_W'(u)) begin
          busyQ <= 1'b1;
        end else if (doneValid[u]) begin
          busyQ <= 1'b0;
        end
      end
      assign unitBusy[u] = busyQ;
    end
  end

  // Register flags: every completing unit clears its own destination
  always_comb begin
    regClr = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (doneValid[u]) regClr[doneRegs[u*REG_W +: REG_W]] = 1'b1;
    end
    regSet = '0;
    if (strobe.claimReg) regSet[dst] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) regBusyQ <= '0;
    else       regBusyQ <= (regBusyQ & ~regClr) | regSet;
  end

  assign regBusy = regBusyQ;
endmodule

// File: rtl/mcu_busy_scoreboard.sv
module mcu_busy_scoreboard
  import mcsb_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int NUM_REGS  = 32,
  parameter logic [NUM_UNITS-1:0] PIPE_MASK = 4'b0001,
  localparam int UNIT_W = $clog2(NUM_UNITS),
  localparam int REG_W  = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       issueValid,
  input  logic [UNIT_W-1:0]          issueUnit,
  input  logic [REG_W-1:0]           srcA,
  input  logic                       srcAUse,
  input  logic [REG_W-1:0]           srcB,
  input  logic                       srcBUse,
  input  logic [REG_W-1:0]           dst,
  input  logic [NUM_UNITS-1:0]       doneValid,
  input  logic [NUM_UNITS*REG_W-1:0] doneRegs,
  output logic                       stall,
  output logic [NUM_UNITS-1:0]       unitBusy,
  output logic [NUM_REGS-1:0]        regBusy
);
  issueStrobe_t strobe;

  mcsb_ctrl #(.NUM_UNITS(NUM_UNITS), .NUM_REGS(NUM_REGS), .PIPE_MASK(PIPE_MASK)) u_ctrl (
    .issueValid(issueValid), .issueUnit(issueUnit),
    .srcA(srcA), .srcAUse(srcAUse), .srcB(srcB), .srcBUse(srcBUse), .dst(dst),
    .unitBusy(unitBusy), .regBusy(regBusy),
    .stall(stall), .strobe(strobe)
  );

  mcsb_flags #(.NUM_UNITS(NUM_UNITS), .NUM_REGS(NUM_REGS), .PIPE_MASK(PIPE_MASK)) u_flags (
    .clk(clk), .rstN(rstN), .strobe(strobe), .issueUnit(issueUnit), .dst(dst),
    .doneValid(doneValid), .doneRegs(doneRegs),
    .unitBusy(unitBusy), .regBusy(regBusy)
  );
endmodule

// File: rtl/mcu_busy_scoreboard_chk.sv
module mcu_busy_scoreboard_chk #(
  parameter int NUM_UNITS = 4,
  parameter int NUM_REGS  = 32,
  parameter logic [NUM_UNITS-1:0] PIPE_MASK = 4'b0001,
  localparam int UNIT_W = $clog2(NUM_UNITS),
  localparam int REG_W  = $clog2(NUM_REGS)
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       issueValid,
  input logic [UNIT_W-1:0]          issueUnit,
  input logic [REG_W-1:0]           srcA,
  input logic                       srcAUse,
  input logic [REG_W-1:0]           srcB,
  input logic                       srcBUse,
  input logic [REG_W-1:0]           dst,
  input logic [NUM_UNITS-1:0]       doneValid,
  input logic [NUM_UNITS*REG_W-1:0] doneRegs,
  input logic                       stall,
  input logic [NUM_UNITS-1:0]       unitBusy,
  input logic [NUM_REGS-1:0]        regBusy
);
  logic lastFire;
  logic [REG_W-1:0] lastDst;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastFire <= 1'b0;
      lastDst  <= '0;
    end else begin
      lastFire <= issueValid && !stall;
      lastDst  <= dst;
    end
  end

  // R5
  idle_no_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !issueValid |-> !stall);
  // R2
  unit_conflict_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && unitBusy[issueUnit] |-> stall);
  // R3
  src_a_conflict_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && srcAUse && regBusy[srcA] |-> stall);
  // R3
  src_b_conflict_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && srcBUse && regBusy[srcB] |-> stall);
  // R4
  dst_conflict_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && regBusy[dst] |-> stall);
  // R6
  issue_marks_dst_chk: assert property (@(posedge clk) disable iff (!rstN)
    lastFire |-> regBusy[lastDst]);

  for (genvar u = 0; u < NUM_UNITS; u++) begin : gDone
    if (!PIPE_MASK[u]) begin : gHold
      // R8
      done_frees_unit_chk: assert property (@(posedge clk) disable iff (!rstN)
        doneValid[u] |=> !unitBusy[u]);
    end
  end
endmodule

bind mcu_busy_scoreboard mcu_busy_scoreboard_chk #(
  .NUM_UNITS(NUM_UNITS), .NUM_REGS(NUM_REGS), .PIPE_MASK(PIPE_MASK)
) u_chk (.*);

// File: tb/mcu_busy_scoreboard_tb.sv
module mcu_busy_scoreboard_tb;
  localparam int NU = 4;
  localparam int NR = 32;
  localparam int UW = 2;
  localparam int RW = 5;
  localparam logic [NU-1:0] PM = 4'b0001;
  localparam int NCYC = 4000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic issueValid = 1'b0;
  logic [UW-1:0] issueUnit = '0;
  logic [RW-1:0] srcA = '0, srcB = '0, dst = '0;
  logic srcAUse = 1'b0, srcBUse = 1'b0;
  logic [NU-1:0] doneValid = '0;
  logic [NU*RW-1:0] doneRegs = '0;
  logic stall;
  logic [NU-1:0] unitBusy;
  logic [NR-1:0] regBusy;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mcu_busy_scoreboard #(.NUM_UNITS(NU), .NUM_REGS(NR), .PIPE_MASK(PM)) u_dut (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueUnit(issueUnit),
    .srcA(srcA), .srcAUse(srcAUse), .srcB(srcB), .srcBUse(srcBUse), .dst(dst),
    .doneValid(doneValid), .doneRegs(doneRegs),
    .stall(stall), .unitBusy(unitBusy), .regBusy(regBusy)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Latency per unit: 0 FP add (pipelined), 1 FP mul, 2 FP div, 3 int mul
  function automatic int latency(input int u);
    case (u)
      0: return 4;
      1: return 4;
      2: return ($urandom % 2) ? 23 : 10;
      default: return 8 + int'($urandom % 9);
    endcase
  endfunction

  // Bench model of the flags
  logic [NU-1:0] mUnit = '0;
  logic [NR-1:0] mReg = '0;
  int ucnt[NU];
  logic [RW-1:0] udst[NU];
  int pc[8];
  logic [RW-1:0] pr[8];
  bit pv[8];

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit pend;
    bit prevFire0;
    int nInstr;
    string flagTag;
    logic [UW-1:0] pu;
    logic [RW-1:0] pa, pb, pd;
    bit pua, pub;
    void'($urandom(32'd20240611));
    for (int s = 0; s < 8; s++) pv[s] = 0;
    for (int u = 0; u < NU; u++) ucnt[u] = 0;
    pend = 0; prevFire0 = 0; nInstr = 0; flagTag = "R1";
    pu = '0; pa = '0; pb = '0; pd = '0; pua = 0; pub = 0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state
    chk(unitBusy == '0, "R1 unitBusy", 64'(unitBusy), 64'h0);
    chk(regBusy == '0, "R1 regBusy", 64'(regBusy), 64'h0);
    chk(stall == 1'b0, "R1 stall", 64'(stall), 64'h0);

    for (int cyc = 0; cyc < NCYC; cyc++) begin
      logic [NU-1:0] dv;
      logic [NU*RW-1:0] dr;
      logic [NR-1:0] clr;
      bit v, expStall, fire, uh, rh, wh;
      string stTag;

      // flags after the previous edge
      chk(regBusy == mReg, {flagTag, " regBusy"}, 64'(regBusy), 64'(mReg));
      chk(unitBusy == mUnit, {flagTag, " unitBusy"}, 64'(unitBusy), 64'(mUnit));

      // completions
      dv = '0; dr = '0;
      for (int u = 1; u < NU; u++) begin
        if (mUnit[u]) begin
          ucnt[u]--;
          if (ucnt[u] == 0) begin dv[u] = 1'b1; dr[u*RW +: RW] = udst[u]; end
        end
      end
      for (int s = 0; s < 8; s++) begin
        if (pv[s]) begin
          pc[s]--;
          if (pc[s] == 0) begin dv[0] = 1'b1; dr[0 +: RW] = pr[s]; pv[s] = 0; end
        end
      end

      // request: held while stalled, directed ones first, then random
      if (!pend) begin
        if (nInstr < 3 || ($urandom % 10) < 8) begin
          pend = 1;
          case (nInstr)
            0: begin pu = 2'd0; pa = 5'd0; pua = 0; pb = 5'd0; pub = 0; pd = 5'd3; end
            1: begin pu = 2'd1; pa = 5'd3; pua = 1; pb = 5'd0; pub = 0; pd = 5'd4; end
            2: begin pu = 2'd1; pa = 5'd0; pua = 0; pb = 5'd0; pub = 0; pd = 5'd5; end
            default: begin
              pu = UW'($urandom % NU);
              pa = RW'($urandom % 8); pua = ($urandom % 2) == 1;
              pb = RW'($urandom % 8); pub = ($urandom % 2) == 1;
              pd = RW'($urandom % 8);
            end
          endcase
          nInstr++;
        end
      end
      v = pend;
      issueValid = v; issueUnit = pu; srcA = pa; srcAUse = pua;
      srcB = pb; srcBUse = pub; dst = pd;
      if (!v) begin
        // unused fields wander while idle
        srcA = RW'($urandom % 8); dst = RW'($urandom % 8); issueUnit = UW'($urandom % NU);
      end
      doneValid = dv; doneRegs = dr;

      uh = mUnit[issueUnit];
      rh = (srcAUse && mReg[srcA]) || (srcBUse && mReg[srcB]);
      wh = mReg[dst];
      expStall = v && (uh || rh || wh);
      if (!v) stTag = "R5";
      else if (uh) stTag = "R2";
      else if (rh) stTag = "R3";
      else if (wh) stTag = "R4";
      else if (pu == 2'd0 && prevFire0) stTag = "R7";
      else stTag = "R6";
      #1;
      chk(stall == expStall, {stTag, " stall"}, 64'(stall), 64'(expStall));

      // model update for the coming edge
      fire = v && !expStall;
      clr = '0;
      for (int u = 0; u < NU; u++) if (dv[u]) clr[dr[u*RW +: RW]] = 1'b1;
      mUnit = mUnit & ~dv;
      mReg = mReg & ~clr;
      if (fire) begin
        mReg[pd] = 1'b1;
        if (!PM[pu]) begin
          mUnit[pu] = 1'b1;
          ucnt[pu] = latency(int'(pu));
          udst[pu] = pd;
        end else begin
          for (int s = 0; s < 8; s++) begin
            if (!pv[s]) begin pv[s] = 1; pc[s] = latency(0); pr[s] = pd; break; end
          end
        end
        pend = 0;
      end
      prevFire0 = fire && (pu == 2'd0);
      if ($countones(dv) >= 2) flagTag = "R9";
      else if (dv != '0) flagTag = "R8";
      else if (v && !fire) flagTag = "R10";
      else flagTag = "R6";

      @(posedge clk);
      @(negedge clk);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule